// File: doc/BRIEF.md
# Torus Hop-Offset Routing Stage

This block is the routing stage of one switch in a two- or three-dimensional torus. Each packet starts with a head flit whose header carries, for every dimension, a signed count of hops still to travel. The stage looks at the header and picks one output port. That port is either the plus or minus link of one dimension, or the local host. It then moves the chosen offset one step toward zero and writes a fresh header check code, because the header bits have changed.

Flits enter on a valid/ready stream with head and tail markers. They leave through a single registered output stage, which carries the flit, its markers and the selected port number. Body and tail flits are not inspected. They take the port chosen for their head and pass through unchanged. Arbitration among ports, buffering and the crossbar sit downstream of this stage.

Top module: `torus_router`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: Head flit layout (defaults): dimension d's offset is a 4-bit two's-complement field at bits [4d+3:4d], with x as d=0, y as d=1 and z as d=2. The 8-bit check code is at bits [19:12]. Bits [31:20] are payload and leave a head flit unchanged.
- R3: Dimensions are resolved in order. The stage acts on the lowest-numbered dimension whose offset is nonzero and leaves every other offset untouched.
- R4: A positive offset selects port 1+2d and is decremented by one. A negative offset selects port 2+2d and is incremented by one.
- R5: When all offsets are zero, the head goes to port 0 (local host) with its offsets unchanged.
- R6: The output check code is the CRC-8 with polynomial 0x07 and initial value 0x00. It is computed over the outgoing offset bits, taken from the highest offset bit down to bit 0. Whatever check code arrived is replaced.
- R7: Extreme offsets follow R4 without wrapping: +7 becomes +6, and -8 becomes -7.
- R8: Non-head flits inside a packet leave with the port chosen for that packet's head and with their data unchanged. The packet ends with the flit that carries the tail marker. A flit with both markers is a one-flit packet.
- R9: A flit accepted while no packet is open and not marked as a head is consumed and never appears at the output.
- R10: A flit accepted on a clock edge is presented at the output from that same edge onward.
- R11: While `outValid` is 1 and `outReady` is 0, the output flit, markers and port hold steady and `inReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input flit present |
| inReady | output | 1 | Stage can take a flit |
| inData | input | 32 | Input flit |
| inHead | input | 1 | Input flit opens a packet |
| inTail | input | 1 | Input flit closes a packet |
| outValid | output | 1 | Output flit present |
| outReady | input | 1 | Downstream takes the flit |
| outData | output | 32 | Output flit, header rewritten on heads |
| outHead | output | 1 | Output flit opens a packet |
| outTail | output | 1 | Output flit closes a packet |
| outPort | output | 3 | Selected port: 0 local, 1+2d plus, 2+2d minus |

## Verification
The stage holds only a few pieces of state: the open-packet flag, the locked port and the output register. A wrong open-packet flag shows up as a stray body flit that gets forwarded, or as a body flit that vanishes. Either is visible on the next output flit, one cycle after acceptance. A wrong locked port shows on the first body flit after the head. Header arithmetic or check-code faults appear on the head flit itself, one cycle after it is accepted. The tests therefore pair each head with its body flits and compare every output field against values derived by hand.

// File: rtl/torus_pkg.sv
package torus_pkg;

  typedef struct packed {
    logic load;
    logic rewrite;
  } ctrlStrobe_t;

  localparam int PORT_LOCAL = 0;

  function automatic int plusPort(input int dim);
    return 1 + 2 * dim;
  endfunction

  function automatic int minusPort(input int dim);
    return 2 + 2 * dim;
  endfunction

endpackage

// File: rtl/torus_ctrl.sv
module torus_ctrl
  import torus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inHead,
  input  logic        inTail,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  output ctrlStrobe_t strobe
);

  logic inPacket;
  logic accept;

  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  always_comb begin
    strobe.load    = accept && (inHead || inPacket);
    strobe.rewrite = accept && inHead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPacket <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (strobe.load) begin
        outValid <= 1'b1;
        if (inHead) inPacket <= !inTail;
        else if (inTail) inPacket <= 1'b0;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

  // R11: a stalled output must close the input
  a_r11_no_ready: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R9: a stray non-head flit leaves nothing at the output
  a_r9_drop: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !inHead && !inPacket) |=> !outValid);

  // R10: an accepted packet flit shows at the output next cycle
  a_r10_latency: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inHead) |=> outValid);

endmodule

// File: rtl/torus_dpath.sv
module torus_dpath
  import torus_pkg::*;
#(
  parameter int NUM_DIMS = 3,
  parameter int OFS_W    = 4,
  parameter int CRC_W    = 8,
  parameter logic [7:0] CRC_POLY = 8'h07,
  parameter int FLIT_W   = 32,
  parameter int PORT_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [FLIT_W-1:0] inData,
  input  logic              inHead,
  input  logic              inTail,
  input  logic              outValid,
  input  logic              outReady,
  output logic [FLIT_W-1:0] outData,
  output logic              outHead,
  output logic              outTail,
  output logic [PORT_W-1:0] outPort
);

  localparam int OFS_BITS = NUM_DIMS * OFS_W;
  localparam int CRC_LSB  = OFS_BITS;

  logic [PORT_W-1:0]   routePort;
  logic [PORT_W-1:0]   lockedPort;
  logic [OFS_BITS-1:0] newOfs;
  logic [FLIT_W-1:0]   rewritten;

  function automatic logic [CRC_W-1:0] calcCrc(input logic [OFS_BITS-1:0] v);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = OFS_BITS - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ v[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY[CRC_W-1:0] : '0);
    end
    return c;
  endfunction

  // route: first nonzero dimension wins, step its offset toward zero
  always_comb begin
    logic found;
    logic [OFS_W-1:0] ofs;
    found     = 1'b0;
    routePort = PORT_W'(PORT_LOCAL);
    newOfs    = inData[OFS_BITS-1:0];
    for (int d = 0; d < NUM_DIMS; d++) begin
      ofs = inData[d*OFS_W +: OFS_W];
      if (!found && (ofs != '0)) begin
        found = 1'b1;
        if (ofs[OFS_W-1]) begin
          routePort = PORT_W'(minusPort(d));
          newOfs[d*OFS_W +: OFS_W] = ofs + 1'b1;
        end else begin
          routePort = PORT_W'(plusPort(d));
          newOfs[d*OFS_W +: OFS_W] = ofs - 1'b1;
        end
      end
    end
  end

  always_comb begin
    rewritten = inData;
    rewritten[OFS_BITS-1:0] = newOfs;
    rewritten[CRC_LSB +: CRC_W] = calcCrc(newOfs);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData    <= '0;
      outHead    <= 1'b0;
      outTail    <= 1'b0;
      outPort    <= '0;
      lockedPort <= '0;
    end else if (strobe.load) begin
      outHead <= inHead;
      outTail <= inTail;
      if (strobe.rewrite) begin
        outData    <= rewritten;
        outPort    <= routePort;
        lockedPort <= routePort;
      end else begin
        outData <= inData;
        outPort <= lockedPort;
      end
    end
  end

  // R11: stalled output holds every field
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) &&
      $stable(outPort) && $stable(outHead) && $stable(outTail)));

  // R5: a head sent to the host carries all-zero offsets
  a_r5_local_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outHead && outPort == PORT_W'(PORT_LOCAL)) |->
      (outData[OFS_BITS-1:0] == '0));

  // R3: a head leaving on dimension d has every lower dimension resolved
  for (genvar d = 1; d < NUM_DIMS; d++) begin : g_order
    a_r3_order: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && outHead && (outPort == PORT_W'(plusPort(d)) ||
        outPort == PORT_W'(minusPort(d)))) |-> (outData[d*OFS_W-1:0] == '0));
  end

endmodule

// File: rtl/torus_router.sv
module torus_router
  import torus_pkg::*;
#(
  parameter int NUM_DIMS = 3,
  parameter int OFS_W    = 4,
  parameter int CRC_W    = 8,
  parameter int FLIT_W   = 32,
  localparam int PORT_W  = $clog2(2 * NUM_DIMS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [FLIT_W-1:0] inData,
  input  logic              inHead,
  input  logic              inTail,
  output logic              outValid,
  input  logic              outReady,
  output logic [FLIT_W-1:0] outData,
  output logic              outHead,
  output logic              outTail,
  output logic [PORT_W-1:0] outPort
);

  ctrlStrobe_t strobe;

  torus_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inHead   (inHead),
    .inTail   (inTail),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );

  torus_dpath #(
    .NUM_DIMS (NUM_DIMS),
    .OFS_W    (OFS_W),
    .CRC_W    (CRC_W),
    .FLIT_W   (FLIT_W),
    .PORT_W   (PORT_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inData   (inData),
    .inHead   (inHead),
    .inTail   (inTail),
    .outValid (outValid),
    .outReady (outReady),
    .outData  (outData),
    .outHead  (outHead),
    .outTail  (outTail),
    .outPort  (outPort)
  );

endmodule

// File: tb/sim_torus_router.sv
module sim_torus_router;

  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic        inValid = 0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic        inHead = 0;
  logic        inTail = 0;
  logic        outValid;
  logic        outReady = 1;
  logic [31:0] outData;
  logic        outHead;
  logic        outTail;
  logic [2:0]  outPort;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  torus_router u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inHead(inHead), .inTail(inTail),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outHead(outHead), .outTail(outTail), .outPort(outPort)
  );

  function automatic logic [7:0] refCrc(input logic [11:0] v);
    logic [7:0] c = 8'h00;
    for (int i = 11; i >= 0; i--) begin
      logic fb = c[7] ^ v[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [31:0] mkFlit(input int x, input int y, input int z,
                                         input logic [7:0] crc, input logic [11:0] pay);
    logic [3:0] xs = 4'(x);
    logic [3:0] ys = 4'(y);
    logic [3:0] zs = 4'(z);
    return {pay, crc, zs, ys, xs};
  endfunction

  function automatic logic [31:0] mkGood(input int x, input int y, input int z,
                                         input logic [11:0] pay);
    logic [11:0] o = {4'(z), 4'(y), 4'(x)};
    return {pay, refCrc(o), o};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic checkOut(input string tag, input logic [2:0] ePort,
                          input logic [31:0] eData, input logic eHead, input logic eTail);
    check(outValid === 1'b1, {tag, " valid"}, 64'(outValid), 64'd1);
    check(outPort === ePort, {tag, " port"}, 64'(outPort), 64'(ePort));
    check(outData === eData, {tag, " data"}, 64'(outData), 64'(eData));
    check({outHead, outTail} === {eHead, eTail}, {tag, " markers"},
          64'({outHead, outTail}), 64'({eHead, eTail}));
  endtask

  // drive at negedge, accepted at next posedge, sampled at following negedge
  task automatic sendFlit(input logic [31:0] d, input logic h, input logic t);
    @(negedge clk);
    inValid = 1; inData = d; inHead = h; inTail = t;
    @(negedge clk);
    inValid = 0; inHead = 0; inTail = 0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(outValid === 1'b0, "R1 outValid after reset", 64'(outValid), 64'd0);
    check(inReady === 1'b1, "R1 inReady after reset", 64'(inReady), 64'd1);
  endtask

  task automatic testXPlus();
    // x=+3 y=-2 z=+1, bogus incoming crc: x decremented, port 1 (R4 R3 R2 R6 R10)
    sendFlit(mkFlit(3, -2, 1, 8'hA5, 12'h9C3), 1, 1);
    checkOut("R4 R3 R6 R10 x plus", 3'd1, mkGood(2, -2, 1, 12'h9C3), 1, 1);
  endtask

  task automatic testYMinus();
    // x=0, y=-2: y incremented, port 4 (R3 R4)
    sendFlit(mkGood(0, -2, 5, 12'h111), 1, 1);
    checkOut("R3 R4 y minus", 3'd4, mkGood(0, -1, 5, 12'h111), 1, 1);
  endtask

  task automatic testLocal();
    // all zero, bad crc replaced by crc of zero (R5 R6)
    sendFlit(mkFlit(0, 0, 0, 8'h3C, 12'hABC), 1, 1);
    checkOut("R5 R6 local", 3'd0, mkGood(0, 0, 0, 12'hABC), 1, 1);
  endtask

  task automatic testExtremes();
    sendFlit(mkGood(0, 0, 7, 12'h001), 1, 1);
    checkOut("R7 z plus 7", 3'd5, mkGood(0, 0, 6, 12'h001), 1, 1);
    sendFlit(mkGood(-8, 7, 7, 12'h002), 1, 1);
    checkOut("R7 x minus 8", 3'd2, mkGood(-7, 7, 7, 12'h002), 1, 1);
    sendFlit(mkGood(0, 0, -8, 12'h003), 1, 1);
    checkOut("R7 z minus 8", 3'd6, mkGood(0, 0, -7, 12'h003), 1, 1);
  endtask

  task automatic testPacket();
    // head y=+1 then body and tail follow port 3 unchanged (R8)
    sendFlit(mkGood(0, 1, -3, 12'h777), 1, 0);
    checkOut("R8 head", 3'd3, mkGood(0, 0, -3, 12'h777), 1, 0);
    sendFlit(32'h0000_0012, 0, 0);
    checkOut("R8 body", 3'd3, 32'h0000_0012, 0, 0);
    sendFlit(32'hDEAD_BEEF, 0, 1);
    checkOut("R8 tail", 3'd3, 32'hDEAD_BEEF, 0, 1);
  endtask

  task automatic testStray();
    // after a tail, a non-head flit is consumed and dropped (R9)
    sendFlit(32'h0000_0001, 0, 0);
    check(outValid === 1'b0, "R9 stray flit dropped", 64'(outValid), 64'd0);
    check(inReady === 1'b1, "R9 stray consumed", 64'(inReady), 64'd1);
    sendFlit(mkGood(-1, 0, 0, 12'h0F0), 1, 1);
    checkOut("R9 next head", 3'd2, mkGood(0, 0, 0, 12'h0F0), 1, 1);
  endtask

  task automatic testBackpressure();
    logic [31:0] firstExp = mkGood(1, 0, 0, 12'h5A5);
    @(negedge clk);
    outReady = 0;
    sendFlit(mkGood(2, 0, 0, 12'h5A5), 1, 1);
    inValid = 1; inData = mkGood(0, 0, 2, 12'h333); inHead = 1; inTail = 1;
    check(inReady === 1'b0, "R11 inReady low", 64'(inReady), 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkOut("R11 hold", 3'd1, firstExp, 1, 1);
      check(inReady === 1'b0, "R11 inReady low held", 64'(inReady), 64'd0);
    end
    outReady = 1;
    @(negedge clk);
    inValid = 0; inHead = 0; inTail = 0;
    checkOut("R11 release", 3'd5, mkGood(0, 0, 1, 12'h333), 1, 1);
    @(negedge clk);
    check(outValid === 1'b0, "R11 drained", 64'(outValid), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    testReset();
    testXPlus();
    testYMinus();
    testLocal();
    testExtremes();
    testPacket();
    testStray();
    testBackpressure();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule